// File: doc/BRIEF.md
# Cross-Domain Entry Switch Unit

This block decides whether a memory reference that leaves the current protection domain may enter another one. It keeps a small cache of entry permissions. Each permission names four things: the accessing domain, the virtual address of an entry point into a target domain, a bit that grants the right to switch, and the address name of the general domain to be entered. A reference marked non-local is compared against the cache, using its virtual address and an accessing domain. That domain is taken either from the general domain base register held in this unit or from the carrier domain base supplied from outside.

On a granted switch the unit first writes the new domain name into the general domain base register. Only after that write does it raise a one-cycle request for an ordinary intra-domain check at the same address. A reference that finds no matching entry reports a miss, so that software can load the permission from its access descriptor through the fill port. A matching entry whose switch right is clear reports a deny. In both of these cases the base register is left untouched.

Top module: `xdom_switch_unit`

## Requirements
- R1: After reset, `gen_base_o` is 0, `busy_o`, `miss_o`, `deny_o` and `check_req_o` are 0, and every cache entry is invalid. A non-local reference to address 0 then reports a miss.
- R2: `base_load_i` writes `base_val_i` into `gen_base_o` at the next edge, but only while `busy_o` is low. While the unit is busy the load is ignored.
- R3: A reference with `ref_nonlocal_i` = 0 is ignored. `busy_o` stays low, no outcome pulse is raised, and `gen_base_o` keeps its value.
- R4: A non-local reference is accepted at edge k if `busy_o` is low. If it matches a valid entry that has the switch right, then `busy_o` is high from edge k to edge k+3 and `gen_base_o` takes the entry's new domain name at edge k+2. `check_req_o` is high for exactly the cycle between edges k+2 and k+3, with `check_va_o` equal to the reference address.
- R5: The accessing domain is `carrier_base_i` when `ref_carrier_i` = 1 and `gen_base_o` otherwise.
- R6: An entry matches only when it is valid and both its accessing domain and its entry address equal those of the reference. With no match, `miss_o` is high for the cycle between edges k and k+1, `busy_o` falls at k+1, and `gen_base_o` is unchanged.
- R7: A match on an entry whose switch right is 0 raises `deny_o` with the same timing as a miss, and leaves `gen_base_o` unchanged.
- R8: The cache holds 8 entries, filled in round-robin order from slot 0. The ninth fill replaces the entry written by the first.
- R9: `flush_i` clears every valid bit. A fill presented in the same cycle as a flush is dropped.
- R10: New references arriving while `busy_o` is high are ignored and do not alter the outcome of the reference in progress.
- R11: When several entries match, the lowest-numbered slot decides the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| fill_valid_i | input | 1 | Write one entry at the round-robin slot |
| fill_dom_i | input | VA_W | Accessing domain of the filled entry |
| fill_entry_va_i | input | VA_W | Entry-point address of the filled entry |
| fill_switch_ok_i | input | 1 | Switch right of the filled entry |
| fill_new_dom_i | input | VA_W | New general domain name of the filled entry |
| ref_valid_i | input | 1 | Reference strobe |
| ref_nonlocal_i | input | 1 | Reference leaves the current domain |
| ref_carrier_i | input | 1 | Use the carrier domain as accessing domain |
| ref_va_i | input | VA_W | Reference virtual address |
| carrier_base_i | input | VA_W | Carrier domain base |
| base_load_i | input | 1 | Direct write of the general domain base |
| base_val_i | input | VA_W | Value for the direct write |
| gen_base_o | output | VA_W | General domain base register |
| busy_o | output | 1 | A reference is being processed |
| miss_o | output | 1 | No matching entry |
| deny_o | output | 1 | Matching entry lacks switch right |
| check_req_o | output | 1 | Request for the intra-domain check |
| check_va_o | output | VA_W | Address for the intra-domain check |

## Verification
The hardest cases to reach are those where the outcome depends on cache history rather than on the current reference. One is a slot that has been silently replaced by round-robin wrap. Another is two entries that both match. The stimulus fills one slot with a denied copy of a permitted entry, then wraps the fill pointer with enough extra fills to overwrite the slot that granted an earlier switch. It then shows that the same reference flips from granted to denied. A second sequence holds a competing reference strobe high through a whole switch, and also issues a base load while a miss is pending. Both are used to show that nothing reaches the base register outside the idle state.

// File: rtl/xdsw_pkg.sv
package xdsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COMPARE = 2'd1,
    ST_UPDATE  = 2'd2,
    ST_REQUEST = 2'd3
  } xdsw_state_e;
endpackage

// File: rtl/xdsw_entry_store.sv
module xdsw_entry_store #(
  parameter int N_ENT = 8,
  parameter int VA_W  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            fill_valid_i,
  input  logic [VA_W-1:0] fill_dom_i,
  input  logic [VA_W-1:0] fill_va_i,
  input  logic            fill_right_i,
  input  logic [VA_W-1:0] fill_new_i,
  output logic [N_ENT-1:0] valid_o,
  output logic [VA_W-1:0] dom_o   [N_ENT],
  output logic [VA_W-1:0] va_o    [N_ENT],
  output logic [N_ENT-1:0] right_o,
  output logic [VA_W-1:0] new_o   [N_ENT]
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (fill_valid_i && !flush_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        right_o[g] <= 1'b0;
        dom_o[g]   <= '0;
        va_o[g]    <= '0;
        new_o[g]   <= '0;
      end else if (flush_i) begin
        valid_o[g] <= 1'b0;
      end else if (fill_valid_i && ptr_q == IDX_W'(g)) begin
        valid_o[g] <= 1'b1;
        right_o[g] <= fill_right_i;
        dom_o[g]   <= fill_dom_i;
        va_o[g]    <= fill_va_i;
        new_o[g]   <= fill_new_i;
      end
    end
  end
endmodule

// File: rtl/xdsw_match.sv
module xdsw_match #(
  parameter int N_ENT = 8,
  parameter int VA_W  = 32
) (
  input  logic [N_ENT-1:0] valid_i,
  input  logic [VA_W-1:0]  dom_i   [N_ENT],
  input  logic [VA_W-1:0]  va_i    [N_ENT],
  input  logic [N_ENT-1:0] right_i,
  input  logic [VA_W-1:0]  new_i   [N_ENT],
  input  logic [VA_W-1:0]  key_dom_i,
  input  logic [VA_W-1:0]  key_va_i,
  output logic             hit_o,
  output logic             right_o,
  output logic [VA_W-1:0]  new_dom_o
);
  logic [N_ENT-1:0] hit_vec;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (dom_i[g] == key_dom_i) && (va_i[g] == key_va_i);
  end

  // scan downward so the lowest matching slot wins
  always_comb begin
    hit_o     = 1'b0;
    right_o   = 1'b0;
    new_dom_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_o     = 1'b1;
        right_o   = right_i[i];
        new_dom_o = new_i[i];
      end
    end
  end
endmodule

// File: rtl/xdsw_ctrl.sv
module xdsw_ctrl
  import xdsw_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_valid_i,
  input  logic            ref_nonlocal_i,
  input  logic            ref_carrier_i,
  input  logic [VA_W-1:0] ref_va_i,
  input  logic [VA_W-1:0] carrier_base_i,
  input  logic            base_load_i,
  input  logic [VA_W-1:0] base_val_i,
  input  logic            hit_i,
  input  logic            right_i,
  input  logic [VA_W-1:0] new_dom_i,
  output logic [VA_W-1:0] key_dom_o,
  output logic [VA_W-1:0] key_va_o,
  output logic [VA_W-1:0] gen_base_o,
  output logic            busy_o,
  output logic            miss_o,
  output logic            deny_o,
  output logic            check_req_o,
  output logic [VA_W-1:0] check_va_o
);
  xdsw_state_e     state_q;
  logic [VA_W-1:0] pend_dom_q;
  logic            accept;

  assign accept = (state_q == ST_IDLE) && ref_valid_i && ref_nonlocal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      key_dom_o  <= '0;
      key_va_o   <= '0;
      pend_dom_q <= '0;
      gen_base_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (base_load_i) gen_base_o <= base_val_i;
          if (accept) begin
            key_dom_o <= ref_carrier_i ? carrier_base_i : gen_base_o;
            key_va_o  <= ref_va_i;
            state_q   <= ST_COMPARE;
          end
        end
        ST_COMPARE: begin
          pend_dom_q <= new_dom_i;
          state_q    <= (hit_i && right_i) ? ST_UPDATE : ST_IDLE;
        end
        ST_UPDATE: begin
          gen_base_o <= pend_dom_q;
          state_q    <= ST_REQUEST;
        end
        ST_REQUEST: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign miss_o      = (state_q == ST_COMPARE) && !hit_i;
  assign deny_o      = (state_q == ST_COMPARE) && hit_i && !right_i;
  assign check_req_o = (state_q == ST_REQUEST);
  assign check_va_o  = key_va_o;
endmodule

// File: rtl/xdom_switch_unit.sv
module xdom_switch_unit #(
  parameter int N_ENT = 8,
  parameter int VA_W  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            fill_valid_i,
  input  logic [VA_W-1:0] fill_dom_i,
  input  logic [VA_W-1:0] fill_entry_va_i,
  input  logic            fill_switch_ok_i,
  input  logic [VA_W-1:0] fill_new_dom_i,
  input  logic            ref_valid_i,
  input  logic            ref_nonlocal_i,
  input  logic            ref_carrier_i,
  input  logic [VA_W-1:0] ref_va_i,
  input  logic [VA_W-1:0] carrier_base_i,
  input  logic            base_load_i,
  input  logic [VA_W-1:0] base_val_i,
  output logic [VA_W-1:0] gen_base_o,
  output logic            busy_o,
  output logic            miss_o,
  output logic            deny_o,
  output logic            check_req_o,
  output logic [VA_W-1:0] check_va_o
);
  logic [N_ENT-1:0] ent_valid, ent_right;
  logic [VA_W-1:0]  ent_dom [N_ENT];
  logic [VA_W-1:0]  ent_va  [N_ENT];
  logic [VA_W-1:0]  ent_new [N_ENT];
  logic [VA_W-1:0]  key_dom, key_va, new_dom;
  logic             hit, right;

  xdsw_entry_store #(.N_ENT(N_ENT), .VA_W(VA_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .fill_valid_i (fill_valid_i),
    .fill_dom_i   (fill_dom_i),
    .fill_va_i    (fill_entry_va_i),
    .fill_right_i (fill_switch_ok_i),
    .fill_new_i   (fill_new_dom_i),
    .valid_o      (ent_valid),
    .dom_o        (ent_dom),
    .va_o         (ent_va),
    .right_o      (ent_right),
    .new_o        (ent_new)
  );

  xdsw_match #(.N_ENT(N_ENT), .VA_W(VA_W)) u_match (
    .valid_i   (ent_valid),
    .dom_i     (ent_dom),
    .va_i      (ent_va),
    .right_i   (ent_right),
    .new_i     (ent_new),
    .key_dom_i (key_dom),
    .key_va_i  (key_va),
    .hit_o     (hit),
    .right_o   (right),
    .new_dom_o (new_dom)
  );

  xdsw_ctrl #(.VA_W(VA_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ref_valid_i    (ref_valid_i),
    .ref_nonlocal_i (ref_nonlocal_i),
    .ref_carrier_i  (ref_carrier_i),
    .ref_va_i       (ref_va_i),
    .carrier_base_i (carrier_base_i),
    .base_load_i    (base_load_i),
    .base_val_i     (base_val_i),
    .hit_i          (hit),
    .right_i        (right),
    .new_dom_i      (new_dom),
    .key_dom_o      (key_dom),
    .key_va_o       (key_va),
    .gen_base_o     (gen_base_o),
    .busy_o         (busy_o),
    .miss_o         (miss_o),
    .deny_o         (deny_o),
    .check_req_o    (check_req_o),
    .check_va_o     (check_va_o)
  );
endmodule

// File: rtl/xdsw_checker.sv
module xdsw_checker #(
  parameter int VA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ref_valid_i,
  input logic            ref_nonlocal_i,
  input logic [VA_W-1:0] gen_base_o,
  input logic            busy_o,
  input logic            miss_o,
  input logic            deny_o,
  input logic            check_req_o
);
  assert_one_outcome_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({miss_o, deny_o, check_req_o}));

  assert_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && ref_nonlocal_i && !busy_o) |=> busy_o);

  assert_req_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_req_o |=> (!check_req_o && !busy_o));

  assert_local_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && !ref_nonlocal_i && !busy_o) |=> !busy_o);

  assert_miss_keeps_base_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> ($stable(gen_base_o) && !busy_o));

  assert_deny_keeps_base_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |=> ($stable(gen_base_o) && !busy_o));
endmodule

bind xdom_switch_unit xdsw_checker #(.VA_W(VA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ref_valid_i    (ref_valid_i),
  .ref_nonlocal_i (ref_nonlocal_i),
  .gen_base_o     (gen_base_o),
  .busy_o         (busy_o),
  .miss_o         (miss_o),
  .deny_o         (deny_o),
  .check_req_o    (check_req_o)
);

// File: tb/xdom_switch_unit_tb.sv
module xdom_switch_unit_tb;
  localparam int VA_W = 32;
  localparam logic [1:0] K_MISS = 2'd0, K_DENY = 2'd1, K_PERMIT = 2'd2, K_LOCAL = 2'd3;

  typedef struct packed {
    logic            nl;
    logic            car;
    logic [VA_W-1:0] va;
    logic [1:0]      kind;
    logic [VA_W-1:0] base;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 1'b0, 32'h4000, K_PERMIT, 32'h200},  // R4
    '{1'b1, 1'b0, 32'h4000, K_MISS,   32'h200},  // R6 domain differs
    '{1'b1, 1'b0, 32'h5000, K_PERMIT, 32'h300},  // R4
    '{1'b0, 1'b0, 32'h4000, K_LOCAL,  32'h300},  // R3
    '{1'b1, 1'b1, 32'h7000, K_PERMIT, 32'h400},  // R5 carrier
    '{1'b1, 1'b0, 32'h7000, K_MISS,   32'h400},  // R5 general
    '{1'b1, 1'b0, 32'h6000, K_MISS,   32'h400}   // R6
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, fill_valid = 0, fill_ok = 0;
  logic [VA_W-1:0] fill_dom = '0, fill_va = '0, fill_new = '0;
  logic ref_valid = 0, ref_nl = 0, ref_car = 0;
  logic [VA_W-1:0] ref_va = '0, carrier_base = 32'h700;
  logic base_load = 0;
  logic [VA_W-1:0] base_val = '0;
  logic [VA_W-1:0] gen_base, check_va;
  logic busy, miss, deny, check_req;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  xdom_switch_unit #(.N_ENT(8), .VA_W(VA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .fill_valid_i(fill_valid), .fill_dom_i(fill_dom), .fill_entry_va_i(fill_va),
    .fill_switch_ok_i(fill_ok), .fill_new_dom_i(fill_new),
    .ref_valid_i(ref_valid), .ref_nonlocal_i(ref_nl), .ref_carrier_i(ref_car),
    .ref_va_i(ref_va), .carrier_base_i(carrier_base),
    .base_load_i(base_load), .base_val_i(base_val),
    .gen_base_o(gen_base), .busy_o(busy), .miss_o(miss), .deny_o(deny),
    .check_req_o(check_req), .check_va_o(check_va)
  );

  task automatic check(input bit ok, input string tag, input logic [VA_W-1:0] act, input logic [VA_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [VA_W-1:0] d, input logic [VA_W-1:0] v, input logic ok, input logic [VA_W-1:0] n, input logic fl);
    @(negedge clk);
    fill_valid = 1; fill_dom = d; fill_va = v; fill_ok = ok; fill_new = n; flush = fl;
    @(negedge clk);
    fill_valid = 0; flush = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic load_base(input logic [VA_W-1:0] v);
    @(negedge clk); base_load = 1; base_val = v;
    @(negedge clk); base_load = 0;
    check(gen_base == v, "R2 load", gen_base, v);
  endtask

  task automatic run_ref(input logic nl, input logic car, input logic [VA_W-1:0] va,
                         input logic [1:0] kind, input logic [VA_W-1:0] eb, input string tag);
    @(negedge clk);
    ref_valid = 1; ref_nl = nl; ref_car = car; ref_va = va;
    @(negedge clk);
    ref_valid = 0;
    case (kind)
      K_LOCAL: begin
        check(!busy && !miss && !deny && !check_req, tag, {28'd0, busy, miss, deny, check_req}, 0);
        check(gen_base == eb, tag, gen_base, eb);
      end
      K_MISS, K_DENY: begin
        check(miss == (kind == K_MISS) && deny == (kind == K_DENY), tag,
              {30'd0, miss, deny}, (kind == K_MISS) ? 2 : 1);
        @(negedge clk);
        check(!busy && gen_base == eb, tag, gen_base, eb);
      end
      default: begin
        check(busy && !miss && !deny, tag, {29'd0, busy, miss, deny}, 4);
        @(negedge clk);
        check(!check_req && gen_base != eb || eb == gen_base && !check_req, tag, {31'd0, check_req}, 0);
        @(negedge clk);
        check(check_req && check_va == va, tag, check_va, va);
        check(gen_base == eb, tag, gen_base, eb);
        @(negedge clk);
        check(!busy && !check_req, tag, {30'd0, busy, check_req}, 0);
      end
    endcase
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(gen_base == 0 && !busy && !miss && !deny && !check_req, "R1 reset", gen_base, 0);
    rst_n = 1;
    run_ref(1, 0, 32'h0, K_MISS, 32'h0, "R1 entries invalid");

    load_base(32'h100);
    fill(32'h100, 32'h4000, 1, 32'h200, 0);   // slot 0
    fill(32'h200, 32'h5000, 1, 32'h300, 0);   // slot 1
    fill(32'h100, 32'h6000, 0, 32'h999, 0);   // slot 2
    fill(32'h700, 32'h7000, 1, 32'h400, 0);   // slot 3

    foreach (VECS[i])
      run_ref(VECS[i].nl, VECS[i].car, VECS[i].va, VECS[i].kind, VECS[i].base, $sformatf("vec%0d", i));

    // R2: load while busy is ignored
    @(negedge clk); ref_valid = 1; ref_nl = 1; ref_car = 0; ref_va = 32'h9999;
    @(negedge clk); ref_valid = 0; base_load = 1; base_val = 32'hDEAD;
    check(busy, "R2 busy", {31'd0, busy}, 1);
    @(negedge clk); base_load = 0;
    @(negedge clk);
    check(gen_base == 32'h400, "R2 load while busy", gen_base, 32'h400);

    load_base(32'h100);
    run_ref(1, 0, 32'h6000, K_DENY, 32'h100, "R7 deny");
    run_ref(1, 0, 32'h4001, K_MISS, 32'h100, "R6 address differs");

    // R10: competing strobe during a switch
    @(negedge clk); ref_valid = 1; ref_nl = 1; ref_car = 0; ref_va = 32'h4000;
    @(negedge clk); ref_va = 32'h4001;
    check(!miss && !deny, "R10 compare", {30'd0, miss, deny}, 0);
    @(negedge clk);
    check(!miss, "R10 update", {31'd0, miss}, 0);
    @(negedge clk); ref_valid = 0;
    check(check_req && check_va == 32'h4000, "R10 request", check_va, 32'h4000);
    check(gen_base == 32'h200, "R10 base", gen_base, 32'h200);
    @(negedge clk);
    check(!busy && !miss, "R10 idle", {30'd0, busy, miss}, 0);

    // R11: lowest slot wins
    load_base(32'h100);
    fill(32'h100, 32'h8000, 0, 32'h555, 0);   // slot 4
    fill(32'h100, 32'h8000, 1, 32'h555, 0);   // slot 5
    run_ref(1, 0, 32'h8000, K_DENY, 32'h100, "R11 priority");

    // R8: wrap replaces slot 0
    fill(32'hF00, 32'h1, 1, 32'h1, 0);        // slot 6
    fill(32'hF00, 32'h2, 1, 32'h2, 0);        // slot 7
    fill(32'h100, 32'h4000, 0, 32'h0, 0);     // slot 0 again
    run_ref(1, 0, 32'h4000, K_DENY, 32'h100, "R8 wrap");
    load_base(32'h200);
    run_ref(1, 0, 32'h5000, K_PERMIT, 32'h300, "R8 slot1 kept");

    // R9: flush
    do_flush();
    load_base(32'h200);
    run_ref(1, 0, 32'h5000, K_MISS, 32'h200, "R9 flush");
    fill(32'h200, 32'h5000, 1, 32'h300, 1);
    run_ref(1, 0, 32'h5000, K_MISS, 32'h200, "R9 fill dropped");
    fill(32'h200, 32'h5000, 1, 32'h300, 0);
    run_ref(1, 0, 32'h5000, K_PERMIT, 32'h300, "R9 refill");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule